// File: doc/BRIEF.md
# Switch Control Register Bank with Two-Wire Slave

This block is the configuration front end for a three-channel buffered mux/demux crosspoint. It contains a two-wire (I2C) slave engine and a small bank of five 8-bit registers. From these registers and from a set of external control pins, it produces the resolved switching controls: a loopback per channel, a select and a bicast. It also produces the per-channel equalizer enable, the 2-bit pre-emphasis level and the output enables.

A mode input chooses between two ways of working. With mode low, the whole switch follows the pins and every output stays enabled. With mode high, the equalizer, pre-emphasis and output-disable settings come from the registers. In that case each of the five switching controls is taken from the pin or from the register, depending on its own mask bit. The serial pins, the mode input and the control pins are sampled on a system clock that runs at least 16 times the SCL rate. Every resolved control leaves the block from a register.

Top module: `xswitch_ctrl_bank`

## Requirements
- R1: After reset, every register reads 0x00 and the register pointer is 0.
- R2: With mode low, lb/sel/bicast/eq/pe outputs equal the pin inputs and all three output enables are 1, regardless of register contents.
- R3: With mode high, eq_o[i] is bit 2 and pe_o[2i+1:2i] is bits 1:0 of register 1+i (channel A=1, B=2, C=3), and oe_o[i] is the inverse of bit 4 of that register.
- R4: Register 0x00 is the mask: bit 0, 1, 2 select the source of loopback A, B, C; bit 3 of select; bit 4 of bicast. With mode high, mask 1 takes the register bit and mask 0 takes the pin (e.g. 0x0C: select and loopback C from registers, the rest from pins).
- R5: Registers 0x01 to 0x03 hold loopback at bit 3 of their channel. Register 0x04 holds select at bit 0 and bicast at bit 1.
- R6: Unused bits (7:5 of 0x00 to 0x03, 7:2 of 0x04) read 0 and ignore writes. Addresses above 0x04 read 0x00 and ignore writes.
- R7: A write is START, 7-bit address 0x48 with R/W bit 0, a pointer byte and data bytes. Each data byte goes to the pointer address, and the pointer then increments. The slave acknowledges each byte by pulling SDA low during the ninth clock.
- R8: A read is a write of the pointer, a repeated START and the address with R/W bit 1. Bytes then come from the current pointer, MSB first. The pointer increments on each master ACK, and the slave stops driving after a master NACK.
- R9: A transfer whose address is not 0x48 gets no acknowledge and changes no register.
- R10: START and STOP are recognised by SDA falling or rising while SCL is high. Clock pulses after a STOP and without a new START are ignored. The slave changes SDA only while SCL is low.
- R11: The mode and control pins each pass two synchronizer flops and an output register. A change driven between clock edges shows on the outputs after the third rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| mode_i | input | 1 | 0 = pin control, 1 = register control |
| pin_lb_i | input | 3 | Loopback pins, channel A in bit 0 |
| pin_sel_i | input | 1 | Select pin |
| pin_bicast_i | input | 1 | Bicast pin |
| pin_eq_i | input | 3 | Equalizer enable pins |
| pin_pe_i | input | 6 | Pre-emphasis pins, 2 bits per channel |
| lb_o | output | 3 | Resolved loopback per channel |
| sel_o | output | 1 | Resolved select |
| bicast_o | output | 1 | Resolved bicast |
| eq_o | output | 3 | Resolved equalizer enables |
| pe_o | output | 6 | Resolved pre-emphasis, 2 bits per channel |
| oe_o | output | 3 | Output enables per channel |

## Verification
The hardest situation to reach is a mixed source pattern. It needs the mode high, a partial mask and register bits that differ from the pins, so that a swapped mask bit or a crossed channel changes a visible output. The bench reaches it by writing random values to the mask and channel registers over the serial bus. It then drives random pins and a random mode and compares all seventeen output bits against a model built from the register contents. Burst reads past the last register, a mismatched address and clock pulses after STOP are directed at the serial engine.

// File: rtl/xsw_pkg.sv
package xsw_pkg;
    localparam int NCH   = 3;
    localparam int MASKW = NCH + 2;
    localparam int REGW  = 5;
    localparam int PEW   = 2 * NCH;

    localparam logic [7:0] A_MASK = 8'h00;
    localparam logic [7:0] A_CH0  = 8'h01;
    localparam logic [7:0] A_GLB  = 8'h04;

    typedef struct packed {
        logic       dis;
        logic       lb;
        logic       eq;
        logic [1:0] pe;
    } chan_cfg_t;

    typedef struct packed {
        logic bicast;
        logic sel;
    } glob_cfg_t;

    typedef struct packed {
        logic [NCH-1:0] lb;
        logic           sel;
        logic           bicast;
        logic [NCH-1:0] eq;
        logic [PEW-1:0] pe;
    } pin_bus_t;

    typedef struct packed {
        logic [NCH-1:0] lb;
        logic           sel;
        logic           bicast;
        logic [NCH-1:0] eq;
        logic [PEW-1:0] pe;
        logic [NCH-1:0] oe;
    } ctl_bus_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_PTR, ST_WR, ST_RD, ST_WAIT
    } slv_st_t;

    function automatic logic pick(input logic use_reg, input logic reg_v, input logic pin_v);
        return use_reg ? reg_v : pin_v;
    endfunction
endpackage

// File: rtl/xsw_sync.sv
module xsw_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            out_q  <= '0;
        end else begin
            meta_q <= d;
            out_q  <= meta_q;
        end
    end

    assign q = out_q;
endmodule

// File: rtl/xsw_i2c_slave.sv
module xsw_i2c_slave
    import xsw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_s,
    input  logic            sda_s,
    output logic            sda_oe,
    output logic            wr_en,
    output logic [7:0]      wr_addr,
    output logic [REGW-1:0] wr_data,
    output logic [7:0]      rd_addr,
    input  logic [7:0]      rd_data
);
    localparam logic [3:0] BITS = 4'd8;

    slv_st_t         state;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg;
    logic [7:0]      txreg;
    logic [7:0]      ptr;
    logic            sda_oe_q;
    logic            in_ack;
    logic            mack;
    logic            wr_en_q;
    logic [7:0]      wr_addr_q;
    logic [REGW-1:0] wr_data_q;
    logic            scl_d;
    logic            sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b0;
            sda_d <= 1'b0;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    wire scl_rise  = scl_s & ~scl_d;
    wire scl_fall  = ~scl_s & scl_d;
    wire start_det = scl_s & scl_d & sda_d & ~sda_s;
    wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txreg     <= '0;
            ptr       <= '0;
            sda_oe_q  <= 1'b0;
            in_ack    <= 1'b0;
            mack      <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (start_det) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                in_ack   <= 1'b0;
                mack     <= 1'b0;
                sda_oe_q <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                bitcnt   <= '0;
                in_ack   <= 1'b0;
                mack     <= 1'b0;
                sda_oe_q <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WR: begin
                        if (in_ack) begin
                            if (scl_fall) begin
                                in_ack   <= 1'b0;
                                sda_oe_q <= 1'b0;
                                bitcnt   <= '0;
                            end
                        end else if (scl_rise && bitcnt != BITS) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == BITS) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    in_ack   <= 1'b1;
                                    sda_oe_q <= 1'b1;
                                    state    <= shreg[0] ? ST_RD : ST_PTR;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else if (state == ST_PTR) begin
                                ptr      <= shreg;
                                in_ack   <= 1'b1;
                                sda_oe_q <= 1'b1;
                                state    <= ST_WR;
                            end else begin
                                wr_en_q   <= 1'b1;
                                wr_addr_q <= ptr;
                                wr_data_q <= shreg[REGW-1:0];
                                ptr       <= ptr + 8'd1;
                                in_ack    <= 1'b1;
                                sda_oe_q  <= 1'b1;
                            end
                        end
                    end
                    ST_RD: begin
                        if (in_ack || mack) begin
                            if (mack && scl_rise) begin
                                if (sda_s) begin
                                    state <= ST_WAIT;
                                    mack  <= 1'b0;
                                end else begin
                                    ptr <= ptr + 8'd1;
                                end
                            end else if (scl_fall) begin
                                in_ack   <= 1'b0;
                                mack     <= 1'b0;
                                txreg    <= rd_data;
                                sda_oe_q <= ~rd_data[7];
                                bitcnt   <= '0;
                            end
                        end else if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == BITS) begin
                                sda_oe_q <= 1'b0;
                                mack     <= 1'b1;
                            end else begin
                                txreg    <= {txreg[6:0], 1'b0};
                                sda_oe_q <= ~txreg[6];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe  = sda_oe_q;
    assign wr_en   = wr_en_q;
    assign wr_addr = wr_addr_q;
    assign wr_data = wr_data_q;
    assign rd_addr = ptr;

    // R10: the slave only moves SDA while SCL is low
    p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_q) |-> !scl_d);

    // R10: a STOP always returns the engine to idle
    p_stop_idles_r10: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> state == ST_IDLE);

    // R7: each register write coincides with the slave acknowledge
    p_write_acked_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en_q |-> sda_oe_q);

    // R8: a master NACK ends the read
    p_nack_ends_read_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD && mack && scl_rise && sda_s && !start_det && !stop_det) |=> state == ST_WAIT);
endmodule

// File: rtl/xsw_regbank.sv
module xsw_regbank
    import xsw_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [7:0]                wr_addr,
    input  logic [REGW-1:0]           wr_data,
    input  logic [7:0]                rd_addr,
    output logic [7:0]                rd_data,
    output logic [MASKW-1:0]          mask_o,
    output chan_cfg_t [NCH-1:0]       chan_o,
    output glob_cfg_t                 glob_o
);
    logic [MASKW-1:0]    mask_q;
    chan_cfg_t [NCH-1:0] chan_q;
    glob_cfg_t           glob_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            glob_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_MASK) mask_q <= wr_data[MASKW-1:0];
            if (wr_addr == A_GLB)  glob_q <= wr_data[1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        localparam logic [7:0] MY_ADDR = A_CH0 + 8'(i);
        always_ff @(posedge clk) begin
            if (rst)                              chan_q[i] <= '0;
            else if (wr_en && wr_addr == MY_ADDR) chan_q[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == A_MASK) rd_data = 8'(mask_q);
        if (rd_addr == A_GLB)  rd_data = 8'(glob_q);
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == A_CH0 + 8'(i)) rd_data = 8'(chan_q[i]);
        end
    end

    assign mask_o = mask_q;
    assign chan_o = chan_q;
    assign glob_o = glob_q;

    // R6: unmapped addresses read as zero
    p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_addr > A_GLB) |-> rd_data == 8'h00);

    // R5: a write to the global register lands select/bicast in bits 0/1
    p_glob_write_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_GLB) |=> glob_q == $past(wr_data[1:0]));
endmodule

// File: rtl/xsw_resolve.sv
module xsw_resolve
    import xsw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_s,
    input  pin_bus_t            pin_s,
    input  logic [MASKW-1:0]    mask_i,
    input  chan_cfg_t [NCH-1:0] chan_i,
    input  glob_cfg_t           glob_i,
    output ctl_bus_t            ctl_o
);
    ctl_bus_t nxt;
    ctl_bus_t ctl_q;

    always_comb begin
        nxt = '0;
        if (!mode_s) begin
            nxt.lb     = pin_s.lb;
            nxt.sel    = pin_s.sel;
            nxt.bicast = pin_s.bicast;
            nxt.eq     = pin_s.eq;
            nxt.pe     = pin_s.pe;
            nxt.oe     = '1;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                nxt.lb[i]       = pick(mask_i[i], chan_i[i].lb, pin_s.lb[i]);
                nxt.eq[i]       = chan_i[i].eq;
                nxt.pe[2*i +: 2] = chan_i[i].pe;
                nxt.oe[i]       = ~chan_i[i].dis;
            end
            nxt.sel    = pick(mask_i[NCH],   glob_i.sel,    pin_s.sel);
            nxt.bicast = pick(mask_i[NCH+1], glob_i.bicast, pin_s.bicast);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= nxt;
    end

    assign ctl_o = ctl_q;

    // R2: pin mode keeps every output enabled
    p_pinmode_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        !mode_s |=> ctl_q.oe == '1);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R4: a set mask bit routes the register loopback bit
        p_mask_src_r4: assert property (@(posedge clk) disable iff (rst)
            (mode_s && mask_i[i]) |=> ctl_q.lb[i] == $past(chan_i[i].lb));
        // R3: register mode equalizer comes from the channel register
        p_eq_from_reg_r3: assert property (@(posedge clk) disable iff (rst)
            mode_s |=> ctl_q.eq[i] == $past(chan_i[i].eq));
    end
endmodule

// File: rtl/xswitch_ctrl_bank.sv
module xswitch_ctrl_bank
    import xsw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           scl_i,
    input  logic           sda_i,
    output logic           sda_oe,
    input  logic           mode_i,
    input  logic [NCH-1:0] pin_lb_i,
    input  logic           pin_sel_i,
    input  logic           pin_bicast_i,
    input  logic [NCH-1:0] pin_eq_i,
    input  logic [PEW-1:0] pin_pe_i,
    output logic [NCH-1:0] lb_o,
    output logic           sel_o,
    output logic           bicast_o,
    output logic [NCH-1:0] eq_o,
    output logic [PEW-1:0] pe_o,
    output logic [NCH-1:0] oe_o
);
    localparam int PINW = 1 + $bits(pin_bus_t);

    logic [1:0]          bus_s;
    logic [PINW-1:0]     pin_raw;
    logic [PINW-1:0]     pin_sync;
    pin_bus_t            pins_in;
    pin_bus_t            pins_s;
    logic                mode_s;
    logic                wr_en;
    logic [7:0]          wr_addr;
    logic [REGW-1:0]     wr_data;
    logic [7:0]          rd_addr;
    logic [7:0]          rd_data;
    logic [MASKW-1:0]    mask;
    chan_cfg_t [NCH-1:0] chan;
    glob_cfg_t           glob;
    ctl_bus_t            ctl;

    xsw_sync #(.W(2)) u_bus_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s)
    );

    always_comb begin
        pins_in.lb     = pin_lb_i;
        pins_in.sel    = pin_sel_i;
        pins_in.bicast = pin_bicast_i;
        pins_in.eq     = pin_eq_i;
        pins_in.pe     = pin_pe_i;
    end

    assign pin_raw = {mode_i, pins_in};

    xsw_sync #(.W(PINW)) u_pin_sync (
        .clk(clk), .rst(rst), .d(pin_raw), .q(pin_sync)
    );

    assign mode_s = pin_sync[PINW-1];
    assign pins_s = pin_sync[PINW-2:0];

    xsw_i2c_slave #(.DEV_ADDR(DEV_ADDR)) u_slave (
        .clk(clk), .rst(rst), .scl_s(bus_s[1]), .sda_s(bus_s[0]), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    xsw_regbank u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .mask_o(mask), .chan_o(chan), .glob_o(glob)
    );

    xsw_resolve u_resolve (
        .clk(clk), .rst(rst), .mode_s(mode_s), .pin_s(pins_s),
        .mask_i(mask), .chan_i(chan), .glob_i(glob), .ctl_o(ctl)
    );

    assign lb_o     = ctl.lb;
    assign sel_o    = ctl.sel;
    assign bicast_o = ctl.bicast;
    assign eq_o     = ctl.eq;
    assign pe_o     = ctl.pe;
    assign oe_o     = ctl.oe;
endmodule

// File: tb/xswitch_ctrl_bank_tb_top.sv
module xswitch_ctrl_bank_tb_top;
    localparam int Q = 8;
    localparam logic [6:0] ADDR = 7'h48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic sda_oe;
    logic sda_bus;
    logic mode = 1'b0;
    logic [2:0] p_lb = '0;
    logic p_sel = 1'b0;
    logic p_bic = 1'b0;
    logic [2:0] p_eq = '0;
    logic [5:0] p_pe = '0;
    logic [2:0] lb_o;
    logic sel_o, bicast_o;
    logic [2:0] eq_o;
    logic [5:0] pe_o;
    logic [2:0] oe_o;

    int checks = 0;
    int fails = 0;
    logic [7:0] model [0:4];

    always #2 clk = ~clk;

    assign sda_bus = ~(m_sda_low | sda_oe);

    xswitch_ctrl_bank dut_i (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .mode_i(mode), .pin_lb_i(p_lb), .pin_sel_i(p_sel), .pin_bicast_i(p_bic),
        .pin_eq_i(p_eq), .pin_pe_i(p_pe),
        .lb_o(lb_o), .sel_o(sel_o), .bicast_o(bicast_o), .eq_o(eq_o), .pe_o(pe_o), .oe_o(oe_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wmask(input int a);
        if (a <= 3) return 8'h1F;
        if (a == 4) return 8'h03;
        return 8'h00;
    endfunction

    function automatic logic [16:0] exp_ctl();
        logic [2:0] lb, eq, oe;
        logic [5:0] pe;
        logic sel, bic;
        if (!mode) return {p_lb, p_sel, p_bic, p_eq, p_pe, 3'b111};
        for (int i = 0; i < 3; i++) begin
            lb[i] = model[0][i] ? model[i+1][3] : p_lb[i];
            eq[i] = model[i+1][2];
            pe[2*i +: 2] = model[i+1][1:0];
            oe[i] = ~model[i+1][4];
        end
        sel = model[0][3] ? model[4][0] : p_sel;
        bic = model[0][4] ? model[4][1] : p_bic;
        return {lb, sel, bic, eq, pe, oe};
    endfunction

    function automatic logic [16:0] act_ctl();
        return {lb_o, sel_o, bicast_o, eq_o, pe_o, oe_o};
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i_start();
        m_sda_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic i_stop();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda_low = 1'b0; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = ~b[i]; wq();
            m_scl = 1'b1; wq(); wq();
            m_scl = 1'b0;
        end
        m_sda_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        ack = ~sda_bus; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic ack);
        m_sda_low = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wq();
            m_scl = 1'b1; wq();
            b = {b[6:0], sda_bus}; wq();
            m_scl = 1'b0;
        end
        m_sda_low = ack; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        m_sda_low = 1'b0;
    endtask

    task automatic wr_burst(input logic [7:0] ptr, input int n, input logic [23:0] dat);
        logic ack;
        i_start();
        send_byte({ADDR, 1'b0}, ack); chk("R7 address ack", ack, 1);
        send_byte(ptr, ack);          chk("R7 pointer ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(dat[8*k +: 8], ack); chk("R7 data ack", ack, 1);
            if (int'(ptr) + k <= 4) model[int'(ptr) + k] = dat[8*k +: 8] & wmask(int'(ptr) + k);
        end
        i_stop();
    endtask

    task automatic rd_burst(input logic [7:0] ptr, input int n, input string tag);
        logic ack;
        logic [7:0] b;
        i_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(ptr, ack);
        i_start();
        send_byte({ADDR, 1'b1}, ack); chk("R8 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k < n - 1);
            chk(tag, b, (int'(ptr) + k <= 4) ? model[int'(ptr) + k] : 8'h00);
        end
        i_stop();
    endtask

    task automatic out_chk(input string tag);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tag, act_ctl(), exp_ctl());
    endtask

    task automatic set_pins(input logic md, input logic [13:0] v);
        mode = md;
        {p_lb, p_sel, p_bic, p_eq, p_pe} = v;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic [16:0] old_exp;
        void'($urandom(32'h5EED_1234));
        for (int a = 0; a < 5; a++) model[a] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset contents
        rd_burst(8'h00, 5, "R1 reset register value");

        // R2: pin mode follows pins, outputs enabled
        set_pins(1'b0, 14'h2A5B);
        out_chk("R2 pin mode outputs");
        wr_burst(8'h01, 3, 24'h1F1F1F);
        set_pins(1'b0, 14'h15A4);
        out_chk("R2 pin mode ignores registers");

        // R4: mask 0x0C example, pins opposite of registers
        wr_burst(8'h00, 1, 24'h00000C);
        wr_burst(8'h03, 2, 24'h000008);
        set_pins(1'b1, {3'b011, 1'b1, 1'b1, 3'b000, 6'h00});
        out_chk("R4 mask 0x0C mixed sources");
        chk("R4 loopback C from register", lb_o, 3'b111);
        chk("R5 select from register bit 0", sel_o, 1'b0);
        chk("R4 bicast from pin", bicast_o, 1'b1);

        // R5/R3: full register control
        wr_burst(8'h00, 1, 24'h00001F);
        wr_burst(8'h01, 3, 24'h0A1506);
        wr_burst(8'h04, 1, 24'h000002);
        set_pins(1'b1, 14'h3FFF);
        out_chk("R3 register eq/pe/output disable");
        chk("R5 bicast from register bit 1", bicast_o, 1'b1);
        chk("R3 output disable bit 4", oe_o, 3'b101);

        // R6: unused bits and unmapped addresses
        wr_burst(8'h04, 2, 24'h00FFFF);
        rd_burst(8'h03, 4, "R8 burst across end of map");
        chk("R6 reg4 unused bits", model[4], 8'h03);
        wr_burst(8'h01, 1, 24'h0000E0);
        rd_burst(8'h01, 1, "R6 unused bits read zero");

        // R9: wrong address ignored
        i_start();
        send_byte({7'h21, 1'b0}, ack); chk("R9 no ack for other address", ack, 0);
        send_byte(8'h02, ack);
        send_byte(8'h1F, ack);
        i_stop();
        rd_burst(8'h02, 1, "R9 register unchanged");

        // R10: clocks after STOP without START ignored
        send_byte({ADDR, 1'b0}, ack); chk("R10 no ack without start", ack, 0);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        i_stop();
        rd_burst(8'h00, 1, "R10 mask unchanged after stray clocks");

        // R11: synchronizer + output register latency
        set_pins(1'b0, 14'h0000);
        out_chk("R11 baseline");
        old_exp = exp_ctl();
        set_pins(1'b0, 14'h3FFF);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 not visible after two edges", act_ctl(), old_exp);
        @(posedge clk);
        @(negedge clk);
        chk("R11 visible after third edge", act_ctl(), exp_ctl());

        // Random mix
        for (int it = 0; it < 24; it++) begin
            int p, n;
            p = $urandom_range(0, 5);
            n = $urandom_range(1, 3);
            wr_burst(8'(p), n, 24'($urandom));
            p = $urandom_range(0, 5);
            n = $urandom_range(1, 3);
            rd_burst(8'(p), n, "R7 R8 random readback");
            set_pins(1'($urandom), 14'($urandom));
            out_chk("R3 R4 random resolve");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule